// File: doc/BRIEF.md
# Interrupt Status and IRQ Pin Generator

This block gathers single-cycle event pulses (FIFO levels, transmit and receive errors, stop notifications, a timer, a PHY event and a software request) into a sticky status register. An enable register selects which pending bits may raise the interrupt, and the enabled bits are combined onto one external interrupt pin whose polarity and driver style (push-pull or open-drain) are programmable.

After the pin drops, an optional hold-off interval keeps it inactive for a programmed number of 10 µs units, so that a host sees a clean gap between two interrupts even when a new event arrives at once. Software reads and writes the status, enable and configuration registers over a simple single-cycle register port. The register offsets are 0 for status, 1 for enable and 2 for configuration; offset 3 reads as zero. The parameter `TICKS_PER_UNIT` gives the number of clock cycles in one 10 µs unit.

Top module: `irq_status_gen`

## Requirements
- R1: An event pulse on an implemented status bit (31, 25, 24, 21, 19, 18, 14, 13, 10, 9, 8, 7, 4, 3; mask 0x832C6798) sets that status bit on the next clock edge and it stays set; pulses on any other bit are ignored and those bits read 0.
- R2: Writing the status register (offset 0) clears each bit written with 1 and leaves bits written with 0 unchanged; writing 0xFFFFFFFF clears everything.
- R3: An event pulse in the same cycle as a write-1-to-clear of the same bit leaves the bit set.
- R4: Writing 1 to bit 31 of the enable register (offset 1) sets status bit 31; the enable register keeps only implemented bits.
- R5: The interrupt is asserted one cycle after (status AND enable) is nonzero, configuration bit 8 is 1 and no hold-off interval runs; clearing bit 8 deasserts it.
- R6: Configuration bit 4 gives polarity: 1 drives `irq_o` high when asserted and low when not; 0 inverts both.
- R7: Configuration bit 0 = 1 selects push-pull (`irq_oe` always 1); 0 selects open-drain (`irq_oe` is 1 only while asserted).
- R8: Configuration bit 12 reads as 1 exactly while the interrupt is asserted.
- R9: When the interrupt deasserts and configuration bits 31:24 hold N > 0, the pin stays inactive for N × `TICKS_PER_UNIT` cycles; N = 0 gives no hold-off.
- R10: Configuration bit 13 reads 1 while a hold-off interval runs; writing the configuration register with bit 14 = 1 ends the interval at once.
- R11: After reset all registers are zero, the interrupt is inactive, `irq_o` is 1 and `irq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one bit per status position |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions take for granted that the event inputs are pulses that need no handshake and that the register port carries at most one write per cycle, with `bus_addr` stable around the sampling edge. The checks on hold-off also assume that a configuration write with bit 14 set is not issued in the very cycle the pin drops. The stimulus drives every input on the falling clock edge, issues one write per task call, and spaces the early-clear write one cycle after the drop, so all runs stay inside these limits.

// File: rtl/irq_status_gen.sv
module irq_status_gen #(
  parameter int TICKS_PER_UNIT = 1250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        irq_oe
);
  localparam logic [31:0] IMPL = 32'h832C_6798;
  localparam int TW = $clog2(TICKS_PER_UNIT + 1);
  localparam int CW = TW + 8;

  logic [31:0]   status, enable;
  logic [7:0]    cfg_gap;
  logic          cfg_en, cfg_pol, cfg_pp;
  logic          irq_q;
  logic [CW-1:0] deas_cnt;

  wire wr_sts = bus_we && bus_addr == 2'd0;
  wire wr_en  = bus_we && bus_addr == 2'd1;
  wire wr_cfg = bus_we && bus_addr == 2'd2;

  wire          deas_run = |deas_cnt;
  wire          pending  = |(status & enable);
  wire          irq_d    = cfg_en && pending && !deas_run;
  wire [31:0]   sts_set  = (evt_i & IMPL) | {wr_en && bus_wdata[31], 31'b0};
  wire [31:0]   sts_clr  = wr_sts ? bus_wdata : 32'b0;
  wire [CW-1:0] gap_load = CW'(cfg_gap) * CW'(TICKS_PER_UNIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      enable  <= '0;
      cfg_gap <= '0;
      cfg_en  <= 1'b0;
      cfg_pol <= 1'b0;
      cfg_pp  <= 1'b0;
    end else begin
      status <= (status & ~sts_clr) | sts_set;
      if (wr_en) enable <= bus_wdata & IMPL;
      if (wr_cfg) begin
        cfg_gap <= bus_wdata[31:24];
        cfg_en  <= bus_wdata[8];
        cfg_pol <= bus_wdata[4];
        cfg_pp  <= bus_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      deas_cnt <= '0;
    end else begin
      irq_q <= irq_d;
      if (wr_cfg && bus_wdata[14])
        deas_cnt <= '0;
      else if (irq_q && !irq_d && cfg_gap != 8'd0)
        deas_cnt <= gap_load;
      else if (deas_run)
        deas_cnt <= deas_cnt - 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = status;
      2'd1:    bus_rdata = enable;
      2'd2:    bus_rdata = {cfg_gap, 10'b0, deas_run, irq_q, 3'b0, cfg_en,
                            3'b0, cfg_pol, 3'b0, cfg_pp};
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o  = irq_q ? cfg_pol : !cfg_pol;
  assign irq_oe = cfg_pp || irq_q;
endmodule

module irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_i,
  input logic [31:0] status,
  input logic [31:0] enable,
  input logic        cfg_en,
  input logic        cfg_pp,
  input logic        irq_q,
  input logic        deas_run,
  input logic        irq_oe,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_rdata
);
  localparam logic [31:0] IMPL = 32'h832C_6798;

  // R1
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~IMPL) == 32'b0);

  // R3
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

  // R5
  assert_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(cfg_en && (|(status & enable))));

  // R7
  drive_style_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe == (cfg_pp || irq_q));

  // R8
  level_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (bus_rdata[12] == irq_q));

  // R9
  holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deas_run |-> !irq_q);
endmodule

bind irq_status_gen irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .status(status), .enable(enable),
  .cfg_en(cfg_en), .cfg_pp(cfg_pp), .irq_q(irq_q), .deas_run(deas_run),
  .irq_oe(irq_oe), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/test_irq_status_gen.sv
module test_irq_status_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, irq_oe;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_status_gen #(.TICKS_PER_UNIT(4)) i_irq_status_gen (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .irq_oe(irq_oe));

  // evt, clear data, expected status
  localparam logic [95:0] VEC [8] = '{
    {32'h0000_0008, 32'h0000_0000, 32'h0000_0008},
    {32'h8040_0000, 32'h0000_0000, 32'h8000_0008},
    {32'h0000_0000, 32'h0000_0008, 32'h8000_0000},
    {32'h0000_2000, 32'h0000_2000, 32'h8000_2000},
    {32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h832C_6798, 32'h0000_0000, 32'h832C_6798},
    {32'h0000_0000, 32'h0001_0100, 32'h832C_6698},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 2'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    idle(3);
    // R11 reset state
    rd(2'd0, r); check("R11 status", r, 32'h0);
    rd(2'd1, r); check("R11 enable", r, 32'h0);
    rd(2'd2, r); check("R11 config", r, 32'h0);
    check("R11 pin", {30'b0, irq_o, irq_oe}, 32'h2);
    rst_n = 1'b1;
    idle(1);

    // R1 R2 R3 vector walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      evt_i = VEC[i][95:64];
      if (VEC[i][63:32] != 32'h0) begin
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = VEC[i][63:32];
      end
      @(negedge clk);
      evt_i = '0; bus_we = 1'b0; bus_wdata = '0;
      rd(2'd0, r);
      check($sformatf("R1/R2/R3 vector %0d", i), r, VEC[i][31:0]);
    end

    // R4 software request through enable
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, r); check("R4 sw status", r, 32'h8000_0000);
    rd(2'd1, r); check("R4 enable mask", r, 32'h832C_6798);

    // R5 R6 R7 R8 asserted, high, push-pull
    wr(2'd2, 32'h0000_0111);
    idle(1);
    check("R5 R6 high asserted", {31'b0, irq_o}, 32'h1);
    check("R7 push-pull oe", {31'b0, irq_oe}, 32'h1);
    rd(2'd2, r); check("R8 level bit", r, 32'h0000_1111);

    // R6 low polarity
    wr(2'd2, 32'h0000_0101);
    idle(1);
    check("R6 low asserted", {31'b0, irq_o}, 32'h0);

    // R7 open-drain
    wr(2'd2, 32'h0000_0110);
    idle(1);
    check("R7 od asserted", {30'b0, irq_o, irq_oe}, 32'h3);
    wr(2'd0, 32'hFFFF_FFFF);
    idle(1);
    check("R7 od released", {30'b0, irq_o, irq_oe}, 32'h0);
    rd(2'd2, r); check("R8 level clear", r, 32'h0000_0110);

    // R5 pin enable off
    wr(2'd1, 32'h8000_0000);
    wr(2'd2, 32'h0000_0011);
    idle(2);
    check("R5 pin disabled", {31'b0, irq_o}, 32'h0);

    // R9 hold-off, 3 units of 4 cycles
    wr(2'd2, 32'h0300_0111);
    idle(1);
    check("R9 armed asserted", {31'b0, irq_o}, 32'h1);
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'h8000_0000);
    idle(4);
    check("R9 held inactive", {31'b0, irq_o}, 32'h0);
    rd(2'd2, r); check("R10 running bit", r, 32'h0300_2111);
    idle(12);
    check("R9 resumes", {31'b0, irq_o}, 32'h1);
    rd(2'd2, r); check("R10 bit idle", r, 32'h0300_1111);

    // R10 early clear
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'h8000_0000);
    wr(2'd2, 32'h0300_4111);
    idle(1);
    check("R10 early clear", {31'b0, irq_o}, 32'h1);

    // R9 zero interval
    wr(2'd2, 32'h0000_0111);
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'h8000_0000);
    idle(1);
    check("R9 no hold-off", {31'b0, irq_o}, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule